// File: doc/BRIEF.md
# Dithered Phase Oscillator and Complex Down-Mixer

The block turns a stream of real input samples into complex baseband samples. A phase accumulator advances by a programmable tuning word once for each accepted sample. The top bits of the accumulated phase address a sine table, and that table supplies both the sine and the cosine weights. Each input sample is multiplied by the cosine to form the in-phase output and by the negated sine to form the quadrature output.

The mixed products are rounded to a wide (20-bit) or narrow (16-bit) result, selected per sample by a single mode bit. The wide mode suits 14- and 16-bit sources. The narrow mode suits 12-bit and floating-point sources.

A loadable starting phase and an optional pseudo-random offset on the phase address the spurs that a table lookup creates at certain tuning words. The offset spreads the periodic table error into a noise floor. A resynchronisation strobe restarts the phase at the programmed value and reseeds the offset generator, so runs are repeatable. Input and output use a valid/ready handshake. The pipeline latency is fixed.

Top module: `dnco_mixer`

## Requirements
- R1: While and directly after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `out_ready` held at 1, a sample accepted in cycle c is presented in cycle c+4. Outputs come out in input order, with none lost and none duplicated.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_i`, `out_q` and `out_valid` hold their values. Once the four pipeline stages are full, `in_ready` is 0.
- R4: With the offset disabled, the k-th sample accepted after a resynchronisation uses phase P = init + k·freq mod 2^32. The table address is P[31:22].
- R5: A cycle with `sync` at 1 loads the accumulator with `init_phase` and reseeds the offset generator. A sample accepted in that same cycle uses `init_phase` itself.
- R6: The table holds q(i) = round(32767·sin(2π(i+0.5)/1024)) for i = 0..255. For address a, with j = a[7:0], the sine is as follows:
  - when a[8] = 1, j is replaced by 255−j;
  - the value is then q(j), negated when a[9] = 1.
  
  The cosine is the sine at address a+256 mod 1024.
- R7: Before rounding, the in-phase product is x·cos and the quadrature product is −x·sin. With `round20` = 1 the result is product/2^10 in 20 bits. With `round20` = 0 the result is product/2^14 in 16 bits, sign-extended onto the 20-bit outputs.
- R8: Rounding is to nearest. An exact half is rounded away from zero.
- R9: A rounded result outside the selected width saturates. In 20-bit mode the limits are −524288 and 524287. In 16-bit mode they are −32768 and 32767.
- R10: The offset generator is a 16-bit Fibonacci LFSR with the following behaviour:
  - it has feedback s15^s13^s12^s10, shifted in at bit 0, and seed 0xACE1;
  - it steps once for every accepted sample, whether or not the offset is enabled;
  - with `dither_en` = 1, its pre-step bits [7:0] are added to the phase at bit 14 before the address is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_x | input | 16 | Signed real input sample |
| sync | input | 1 | Resynchronise phase and offset generator |
| freq_word | input | 32 | Phase increment per sample |
| init_phase | input | 32 | Phase loaded on resynchronisation |
| dither_en | input | 1 | Add pseudo-random phase offset |
| round20 | input | 1 | 1 selects 20-bit results, 0 selects 16-bit results |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output |
| out_i | output | 20 | Signed in-phase result |
| out_q | output | 20 | Signed quadrature result |

## Verification
The bench sweeps every table address so that each quadrant fold is exercised. An off-by-one fold or a wrong quadrant sign then shows up as a wrong value at a quadrant edge.

Exact-half products with both signs separate round-away-from-zero from truncation or floor rounding. Full-scale inputs in both widths expose a result that wraps instead of saturating.

A run with the offset enabled, after the generator has already stepped through undithered samples, catches two faults: an LFSR that only steps while the offset is on, and an offset applied at the wrong bit. A sample carrying `sync`, and a stalled output during a full pipeline, show a stale start phase, lost samples or outputs that change while held.

// File: rtl/dnco_pkg.sv
package dnco_pkg;

  localparam real PI_C = 3.14159265358979323846;

  typedef enum logic {
    RND_NARROW = 1'b0,
    RND_WIDE   = 1'b1
  } rnd_mode_e;

  // Positive quarter-wave sample with a half-step offset, so that all four
  // quadrants fold exactly onto one table.
  function automatic int quarter_sine(input int idx, input int full_n, input int amp);
    real ang;
    real v;
    ang = 2.0 * PI_C * (real'(idx) + 0.5) / real'(full_n);
    v   = real'(amp) * $sin(ang);
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/dnco_phase.sv
module dnco_phase #(
  parameter int                PHASE_W   = 32,
  parameter int                ADDR_W    = 10,
  parameter int                DITH_W    = 8,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               accept,
  input  logic               sync,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [PHASE_W-1:0] init_phase,
  input  logic               dither_en,
  output logic [ADDR_W-1:0]  addr_q
);

  localparam int ADDR_LSB = PHASE_W - ADDR_W;
  localparam int DITH_SH  = ADDR_LSB - DITH_W;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction

  logic [PHASE_W-1:0] acc_q;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [PHASE_W-1:0] phase_used;
  logic [LFSR_W-1:0]  lfsr_used;
  logic [PHASE_W-1:0] dith_add;
  logic [ADDR_W-1:0]  addr_next;

  always_comb begin
    phase_used = sync ? init_phase : acc_q;
    lfsr_used  = sync ? LFSR_SEED  : lfsr_q;
    dith_add   = dither_en ? (PHASE_W'(lfsr_used[DITH_W-1:0]) << DITH_SH) : '0;
    addr_next  = ADDR_W'((phase_used + dith_add) >> ADDR_LSB);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lfsr_q <= LFSR_SEED;
      addr_q <= '0;
    end else begin
      if (accept) begin
        acc_q  <= phase_used + freq_word;
        lfsr_q <= lfsr_step(lfsr_used);
      end else if (sync) begin
        acc_q  <= init_phase;
        lfsr_q <= LFSR_SEED;
      end
      if (en) addr_q <= addr_next;
    end
  end

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R5
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync) && !$past(accept)) |-> (acc_q == $past(init_phase)));

endmodule

// File: rtl/dnco_sincos.sv
module dnco_sincos #(
  parameter int ADDR_W = 10,
  parameter int LUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [LUT_W-1:0]  sin_q,
  output logic signed [LUT_W-1:0]  cos_q
);

  localparam int FULL_N = 2 ** ADDR_W;
  localparam int QN     = FULL_N / 4;
  localparam int AMP    = 2 ** (LUT_W - 1) - 1;

  logic [LUT_W-1:0] qtab [QN];

  for (genvar g = 0; g < QN; g++) begin : g_tab
    assign qtab[g] = LUT_W'(dnco_pkg::quarter_sine(g, FULL_N, AMP));
  end

  function automatic logic signed [LUT_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-3:0] j;
    logic signed [LUT_W-1:0] v;
    j = a[ADDR_W-2] ? ~a[ADDR_W-3:0] : a[ADDR_W-3:0];
    v = $signed(qtab[j]);
    return a[ADDR_W-1] ? -v : v;
  endfunction

  logic [ADDR_W-1:0]       cos_addr;
  logic signed [LUT_W-1:0] sin_d;
  logic signed [LUT_W-1:0] cos_d;

  always_comb begin
    cos_addr = addr + ADDR_W'(QN);
    sin_d    = fold(addr);
    cos_d    = fold(cos_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else if (en) begin
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

  // R6
  lut_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_q >= -AMP) && (sin_q <= AMP) && (cos_q >= -AMP) && (cos_q <= AMP));

endmodule

// File: rtl/dnco_mix.sv
module dnco_mix #(
  parameter int IN_W     = 16,
  parameter int LUT_W    = 16,
  parameter int OUT_W    = 20,
  parameter int NARROW_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x,
  input  logic signed [LUT_W-1:0] sin_v,
  input  logic signed [LUT_W-1:0] cos_v,
  input  dnco_pkg::rnd_mode_e     mode,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  import dnco_pkg::*;

  localparam int PROD_W    = IN_W + LUT_W;
  localparam int SH_WIDE   = PROD_W - OUT_W - 2;
  localparam int SH_NARROW = PROD_W - NARROW_W - 2;
  localparam int NAR_MAX   = 2 ** (NARROW_W - 1) - 1;
  localparam int NAR_MIN   = -(2 ** (NARROW_W - 1));

  function automatic logic signed [OUT_W-1:0] round_sat(input longint p, input int sh, input int w);
    longint half;
    longint mag;
    longint r;
    longint hi;
    longint lo;
    half = longint'(1) <<< (sh - 1);
    mag  = (p < 0) ? -p : p;
    r    = (mag + half) >>> sh;
    if (p < 0) r = -r;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return OUT_W'(r);
  endfunction

  logic signed [PROD_W-1:0] prod_i_q;
  logic signed [PROD_W-1:0] prod_q_q;
  rnd_mode_e                mode3_q;
  rnd_mode_e                mode4_q;
  int                       sh_sel;
  int                       w_sel;

  always_comb begin
    sh_sel = (mode3_q == RND_WIDE) ? SH_WIDE : SH_NARROW;
    w_sel  = (mode3_q == RND_WIDE) ? OUT_W   : NARROW_W;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_i_q <= '0;
      prod_q_q <= '0;
      mode3_q  <= RND_NARROW;
      mode4_q  <= RND_NARROW;
      out_i    <= '0;
      out_q    <= '0;
    end else if (en) begin
      prod_i_q <= x * cos_v;
      prod_q_q <= -(x * sin_v);
      mode3_q  <= mode;
      mode4_q  <= mode3_q;
      out_i    <= round_sat(longint'(prod_i_q), sh_sel, w_sel);
      out_q    <= round_sat(longint'(prod_q_q), sh_sel, w_sel);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode4_q == RND_NARROW) |-> ((out_i >= NAR_MIN) && (out_i <= NAR_MAX) &&
                                 (out_q >= NAR_MIN) && (out_q <= NAR_MAX)));

endmodule

// File: rtl/dnco_mixer.sv
module dnco_mixer #(
  parameter int                PHASE_W   = 32,
  parameter int                ADDR_W    = 10,
  parameter int                IN_W      = 16,
  parameter int                LUT_W     = 16,
  parameter int                OUT_W     = 20,
  parameter int                NARROW_W  = 16,
  parameter int                DITH_W    = 8,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_x,
  input  logic                    sync,
  input  logic [PHASE_W-1:0]      freq_word,
  input  logic [PHASE_W-1:0]      init_phase,
  input  logic                    dither_en,
  input  logic                    round20,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  import dnco_pkg::*;

  localparam int STAGES = 4;

  logic                    stage_en;
  logic                    accept;
  logic [STAGES-1:0]       vld_q;
  logic signed [IN_W-1:0]  x1_q;
  logic signed [IN_W-1:0]  x2_q;
  rnd_mode_e               mode1_q;
  rnd_mode_e               mode2_q;
  logic [ADDR_W-1:0]       addr_q;
  logic signed [LUT_W-1:0] sin_q;
  logic signed [LUT_W-1:0] cos_q;

  assign stage_en  = !vld_q[STAGES-1] || out_ready;
  assign accept    = in_valid && stage_en;
  assign in_ready  = stage_en;
  assign out_valid = vld_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      x1_q    <= '0;
      x2_q    <= '0;
      mode1_q <= RND_NARROW;
      mode2_q <= RND_NARROW;
    end else if (stage_en) begin
      vld_q   <= {vld_q[STAGES-2:0], in_valid};
      x1_q    <= in_x;
      x2_q    <= x1_q;
      mode1_q <= rnd_mode_e'(round20);
      mode2_q <= mode1_q;
    end
  end

  dnco_phase #(
    .PHASE_W  (PHASE_W),
    .ADDR_W   (ADDR_W),
    .DITH_W   (DITH_W),
    .LFSR_W   (LFSR_W),
    .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (stage_en),
    .accept    (accept),
    .sync      (sync),
    .freq_word (freq_word),
    .init_phase(init_phase),
    .dither_en (dither_en),
    .addr_q    (addr_q)
  );

  dnco_sincos #(
    .ADDR_W(ADDR_W),
    .LUT_W (LUT_W)
  ) u_sincos (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (stage_en),
    .addr (addr_q),
    .sin_q(sin_q),
    .cos_q(cos_q)
  );

  dnco_mix #(
    .IN_W    (IN_W),
    .LUT_W   (LUT_W),
    .OUT_W   (OUT_W),
    .NARROW_W(NARROW_W)
  ) u_mix (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (stage_en),
    .x    (x2_q),
    .sin_v(sin_q),
    .cos_v(cos_q),
    .mode (mode2_q),
    .out_i(out_i),
    .out_q(out_q)
  );

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

endmodule

// File: tb/dnco_mixer_bench.sv
module dnco_mixer_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_x = '0;
  logic               sync = 1'b0;
  logic [31:0]        freq_word = '0;
  logic [31:0]        init_phase = '0;
  logic               dither_en = 1'b0;
  logic               round20 = 1'b1;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic signed [19:0] out_i;
  logic signed [19:0] out_q;

  dnco_mixer u_dnco_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .sync(sync), .freq_word(freq_word), .init_phase(init_phase),
    .dither_en(dither_en), .round20(round20), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  localparam logic [15:0] SEED = 16'hACE1;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  int    exp_i[$];
  int    exp_q[$];
  string exp_tag[$];
  logic [31:0] m_acc = '0;
  logic [15:0] m_lfsr = SEED;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_sine(input int k);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / 1024.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int ref_round(input longint p, input bit wide);
    longint d;
    longint q;
    longint r;
    longint hi;
    d  = wide ? 64'sd1024 : 64'sd16384;
    hi = wide ? 64'sd524287 : 64'sd32767;
    q  = p / d;
    r  = p % d;
    if (r < 0) r = -r;
    if (2 * r >= d) q = q + ((p < 0) ? -1 : 1);
    if (q > hi) q = hi;
    if (q < -hi - 1) q = -hi - 1;
    return int'(q);
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  task automatic model(input int x, input bit r20, input bit dith, input bit syn, input string tag);
    logic [31:0] base;
    logic [31:0] ph;
    logic [15:0] l;
    int a;
    int s;
    int c;
    base = syn ? init_phase : m_acc;
    l    = syn ? SEED : m_lfsr;
    ph   = base;
    if (dith) ph = ph + (32'(l[7:0]) * 32'd16384);
    a = int'(ph[31:22]);
    s = ref_sine(a);
    c = ref_sine((a + 256) % 1024);
    exp_i.push_back(ref_round(longint'(x) * longint'(c), r20));
    exp_q.push_back(ref_round(-(longint'(x) * longint'(s)), r20));
    exp_tag.push_back(tag);
    m_acc  = base + freq_word;
    m_lfsr = lfsr_next(l);
  endtask

  task automatic send(input int x, input bit r20, input bit dith, input bit syn, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_x      = 16'(x);
    round20   = r20;
    dither_en = dith;
    sync      = syn;
    while (!in_ready) @(negedge clk);
    model(x, r20, dith, syn, tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    sync     = 1'b0;
  endtask

  task automatic resync(input logic [31:0] ph);
    @(negedge clk);
    init_phase = ph;
    sync = 1'b1;
    m_acc  = ph;
    m_lfsr = SEED;
    @(posedge clk);
    #1;
    sync = 1'b0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
    check(exp_i.size() == 0, "R2 pending outputs", exp_i.size(), 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_i.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'(out_i), 0);
      end else begin
        int    ei;
        int    eq;
        string t;
        ei = exp_i.pop_front();
        eq = exp_q.pop_front();
        t  = exp_tag.pop_front();
        check(int'(out_i) == ei, {t, " out_i"}, int'(out_i), ei);
        check(int'(out_q) == eq, {t, " out_q"}, int'(out_q), eq);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int held_i;
    int held_q;
    bit seen;

    repeat (5) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R4: plain accumulation, 20-bit results
    freq_word = 32'h0123_4567;
    resync(32'h0000_0000);
    for (int n = 0; n < 40; n++) send(((n * 7919) % 30000) - 15000, 1'b1, 1'b0, 1'b0, "R4");
    drain();

    // R2: fixed latency
    begin
      send(12000, 1'b1, 1'b0, 1'b0, "R2");
      seen = 1'b0;
      for (int c = 1; c <= 4; c++) begin
        @(negedge clk);
        if (c < 4) check(out_valid == 1'b0, "R2 early valid", int'(out_valid), 0);
        else       check(out_valid == 1'b1, "R2 valid at cycle 4", int'(out_valid), 1);
      end
    end
    drain();

    // R7: 16-bit mode with a different tuning word
    freq_word = 32'h3A5C_0F11;
    for (int n = 0; n < 30; n++) send(((n * 4099) % 60000) - 30000, 1'b0, 1'b0, 1'b0, "R7");
    drain();

    // R5: sync carried by a sample, then sync alone
    init_phase = 32'h4000_0000;
    send(20000, 1'b1, 1'b0, 1'b1, "R5");
    send(-20000, 1'b1, 1'b0, 1'b0, "R5");
    resync(32'hC123_0000);
    send(9000, 1'b0, 1'b0, 1'b0, "R5");
    send(-9000, 1'b1, 1'b0, 1'b0, "R5");
    drain();

    // R6: every table address, one step per sample
    freq_word = 32'h0040_0000;
    resync(32'h0000_0000);
    for (int n = 0; n < 1024; n++) send(16383, 1'b1, 1'b0, 1'b0, "R6");
    drain();

    // R8: exact halves at phase 0 (cosine 32767)
    freq_word = 32'h0;
    resync(32'h0000_0000);
    send(512, 1'b1, 1'b0, 1'b0, "R8");
    send(-512, 1'b1, 1'b0, 1'b0, "R8");
    send(8192, 1'b0, 1'b0, 1'b0, "R8");
    send(-8192, 1'b0, 1'b0, 1'b0, "R8");
    send(1536, 1'b1, 1'b0, 1'b0, "R8");
    drain();

    // R9: saturation in both widths
    send(32767, 1'b1, 1'b0, 1'b0, "R9");
    send(-32768, 1'b1, 1'b0, 1'b0, "R9");
    send(32767, 1'b0, 1'b0, 1'b0, "R9");
    send(-32768, 1'b0, 1'b0, 1'b0, "R9");
    drain();

    // R10: offset on after the generator has stepped undithered
    freq_word = 32'h0555_1234;
    resync(32'h0100_0000);
    for (int n = 0; n < 10; n++) send(10000 - n * 1500, 1'b1, 1'b0, 1'b0, "R10");
    for (int n = 0; n < 60; n++) send(((n * 1237) % 32000) - 16000, n[0], 1'b1, 1'b0, "R10");
    for (int n = 0; n < 10; n++) send(7000 + n * 900, 1'b1, 1'b0, 1'b0, "R10");
    drain();

    // R3: back-pressure with a full pipeline
    @(negedge clk);
    out_ready = 1'b0;
    for (int n = 0; n < 4; n++) send(3000 * (n + 1), 1'b1, 1'b0, 1'b0, "R3");
    @(negedge clk);
    check(in_ready == 1'b0, "R3 in_ready when full", int'(in_ready), 0);
    held_i = int'(out_i);
    held_q = int'(out_q);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R3 valid held", int'(out_valid), 1);
      check(int'(out_i) == held_i && int'(out_q) == held_q, "R3 data held", int'(out_i), held_i);
    end
    out_ready = 1'b1;
    drain();

    report();
  end

endmodule